// File: doc/BRIEF.md
# Lane Self-Test Defect Mapper

This block checks a bundle of parallel die-to-die lanes. It runs a short self-test with no help from software, and the result is a per-lane defect map. The test starts on its own when reset is released. The transmit half drives a fixed number of all-ones words across the lanes, then the same number of all-zeros words. The receive half takes the words that come back, one per strobe. It compares each bit with the value expected for the current pass and counts the disagreements for every lane on its own.

A lane is marked defective only when it disagreed on every transfer of the ones pass or on every transfer of the zeros pass. A lane stuck at either level is therefore located exactly. A lane that fails only some transfers is not marked. Each direction of a link pair is mapped by its own instance. The map is captured when the test completes, and a flag shows when more than one lane is marked. A later start request reruns the test and rebuilds the map.

Top module: `lane_selftest_mapper`

## Requirements
- R1: One clock edge after reset is released, the block begins transmitting with no start request. `done_o` stays low until the test completes.
- R2: While the test runs, `tx_valid_o` is high for exactly 2*REPS consecutive cycles. The first REPS words on `tx_lanes_o` are all ones and the next REPS words are all zeros. Whenever `tx_valid_o` is low, `tx_lanes_o` is all zeros.
- R3: A receive word is counted only on a cycle with `rx_strobe_i` high while the test runs. The first REPS counted words are compared with all ones and the next REPS with all zeros. Words on non-strobe cycles have no effect on the map.
- R4: Bit i of `defect_map_o` is 1 exactly when lane i mismatched on all REPS words of the ones pass or on all REPS words of the zeros pass. A lane with REPS-1 or fewer mismatches in each pass reads 0.
- R5: `done_o` rises on the clock edge that accepts the 2*REPS-th counted word. `defect_map_o` and `multi_defect_o` take their new values on that same edge.
- R6: Reset sets `defect_map_o` and `multi_defect_o` to 0. Between reset or a start and completion, both keep their previous values.
- R7: `multi_defect_o` is 1 exactly when two or more bits of `defect_map_o` are 1.
- R8: A `start_i` pulse while `done_o` is high clears all lane counters and reruns the test. `done_o` falls on the next edge and transmission begins one edge later. A `start_i` pulse while the test runs has no effect.
- R9: Strobed words that arrive while `done_o` is high leave `defect_map_o`, `multi_defect_o` and `done_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; releasing it starts a test |
| start_i | input | 1 | Rerun request, taken only while done_o is high |
| tx_valid_o | output | 1 | A test word is on tx_lanes_o this cycle |
| tx_lanes_o | output | LANES | Test word driven onto the lanes |
| rx_strobe_i | input | 1 | rx_lanes_i holds a received word this cycle |
| rx_lanes_i | input | LANES | Word captured from the far end of the lanes |
| done_o | output | 1 | Test complete, map valid |
| defect_map_o | output | LANES | One bit per lane, 1 = lane defective |
| multi_defect_o | output | 1 | More than one lane is marked defective |

## Verification
The assertions assume that `rst` is held high for at least one clock edge before anything is checked. They do not assume any order between strobes and transmitted words. The receive half is free-running against its own count, so the checks rely only on the port-level sequence of transmit words and on completion following a strobe. The stimulus uses a stuck-at-zero mask, a stuck-at-one mask and a "fails all but the last word" mask that stay fixed within one test. The masks change only between tests. Idle gaps between strobes carry inverted data, so any word counted by mistake would show up in the map.

// File: rtl/lst_pkg.sv
package lst_pkg;

    // Top-level sequencing states of the self-test.
    typedef enum logic [1:0] {
        ST_KICK = 2'd0,   // clear counters, arm both halves
        ST_RUN  = 2'd1,   // transmit and collect
        ST_DONE = 2'd2    // map captured, waiting for a rerun
    } lst_state_e;

    // Which pass a word belongs to.
    typedef enum logic {
        PH_ONES  = 1'b0,
        PH_ZEROS = 1'b1
    } lst_phase_e;

    // Control bundle from the sequencer to the lane datapath.
    typedef struct packed {
        logic       clear;    // zero every lane counter
        logic       accept;   // a strobed word is counted this cycle
        lst_phase_e rx_phase; // pass the counted word belongs to
        logic       finish;   // this accepted word is the last one
    } lst_ctrl_t;

    // Expected bit for a given pass.
    function automatic logic expected_bit(lst_phase_e ph);
        return (ph == PH_ONES);
    endfunction

endpackage

// File: rtl/lst_seq_ctrl.sv
module lst_seq_ctrl
    import lst_pkg::*;
#(
    parameter int REPS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       rx_strobe_i,
    output logic       tx_valid_o,
    output lst_phase_e tx_phase_o,
    output logic       done_o,
    output lst_ctrl_t  ctrl_o
);

    localparam int CNT_W = $clog2(2 * REPS + 1);
    localparam logic [CNT_W-1:0] HALF  = CNT_W'(REPS);
    localparam logic [CNT_W-1:0] TOTAL = CNT_W'(2 * REPS);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(2 * REPS - 1);

    lst_state_e       state_q, state_d;
    logic [CNT_W-1:0] tx_cnt_q, tx_cnt_d;
    logic [CNT_W-1:0] rx_cnt_q, rx_cnt_d;
    logic             accept;
    logic             finish;

    assign accept = (state_q == ST_RUN) && rx_strobe_i;
    assign finish = accept && (rx_cnt_q == LAST);

    always_comb begin
        state_d  = state_q;
        tx_cnt_d = tx_cnt_q;
        rx_cnt_d = rx_cnt_q;
        unique case (state_q)
            ST_KICK: begin
                tx_cnt_d = '0;
                rx_cnt_d = '0;
                state_d  = ST_RUN;
            end
            ST_RUN: begin
                if (tx_cnt_q < TOTAL) begin
                    tx_cnt_d = tx_cnt_q + 1'b1;
                end
                if (accept) begin
                    rx_cnt_d = rx_cnt_q + 1'b1;
                end
                if (finish) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                if (start_i) begin
                    state_d = ST_KICK;
                end
            end
            default: state_d = ST_KICK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_KICK;
            tx_cnt_q <= '0;
            rx_cnt_q <= '0;
        end else begin
            state_q  <= state_d;
            tx_cnt_q <= tx_cnt_d;
            rx_cnt_q <= rx_cnt_d;
        end
    end

    assign tx_valid_o = (state_q == ST_RUN) && (tx_cnt_q < TOTAL);
    assign tx_phase_o = (tx_cnt_q < HALF) ? PH_ONES : PH_ZEROS;
    assign done_o     = (state_q == ST_DONE);

    assign ctrl_o.clear    = (state_q == ST_KICK);
    assign ctrl_o.accept   = accept;
    assign ctrl_o.rx_phase = (rx_cnt_q < HALF) ? PH_ONES : PH_ZEROS;
    assign ctrl_o.finish   = finish;

endmodule

// File: rtl/lst_lane_counter.sv
module lst_lane_counter
    import lst_pkg::*;
#(
    parameter int REPS = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  lst_ctrl_t ctrl_i,
    input  logic      rx_bit_i,
    output logic      verdict_o
);

    localparam int LC_W = $clog2(REPS + 1);
    localparam logic [LC_W-1:0] KMAX = LC_W'(REPS);

    logic [LC_W-1:0] ones_miss_q, ones_miss_d;
    logic [LC_W-1:0] zero_miss_q, zero_miss_d;
    logic            miss;

    assign miss = ctrl_i.accept && (rx_bit_i != expected_bit(ctrl_i.rx_phase));

    // Saturating per-pass mismatch counts.
    always_comb begin
        ones_miss_d = ones_miss_q;
        zero_miss_d = zero_miss_q;
        if (miss) begin
            if (ctrl_i.rx_phase == PH_ONES) begin
                if (ones_miss_q != KMAX) begin
                    ones_miss_d = ones_miss_q + 1'b1;
                end
            end else begin
                if (zero_miss_q != KMAX) begin
                    zero_miss_d = zero_miss_q + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctrl_i.clear) begin
            ones_miss_q <= '0;
            zero_miss_q <= '0;
        end else begin
            ones_miss_q <= ones_miss_d;
            zero_miss_q <= zero_miss_d;
        end
    end

    // Verdict including the word accepted this cycle.
    assign verdict_o = (ones_miss_d == KMAX) || (zero_miss_d == KMAX);

endmodule

// File: rtl/lst_map_reg.sv
module lst_map_reg #(
    parameter int LANES = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture_i,
    input  logic [LANES-1:0] verdict_i,
    output logic [LANES-1:0] map_o,
    output logic             multi_o
);

    logic [1:0] seen;

    // Saturating count of flagged lanes: 0, 1, or 2 meaning "two or more".
    always_comb begin
        seen = 2'd0;
        for (int l = 0; l < LANES; l++) begin
            if (verdict_i[l] && (seen != 2'd2)) begin
                seen = seen + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            map_o   <= '0;
            multi_o <= 1'b0;
        end else if (capture_i) begin
            map_o   <= verdict_i;
            multi_o <= (seen == 2'd2);
        end
    end

endmodule

// File: rtl/lane_selftest_mapper.sv
module lane_selftest_mapper
    import lst_pkg::*;
#(
    parameter int LANES = 32,
    parameter int REPS  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             tx_valid_o,
    output logic [LANES-1:0] tx_lanes_o,
    input  logic             rx_strobe_i,
    input  logic [LANES-1:0] rx_lanes_i,
    output logic             done_o,
    output logic [LANES-1:0] defect_map_o,
    output logic             multi_defect_o
);

    lst_ctrl_t        ctrl;
    lst_phase_e       tx_phase;
    logic [LANES-1:0] verdict;

    lst_seq_ctrl #(.REPS(REPS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .rx_strobe_i (rx_strobe_i),
        .tx_valid_o  (tx_valid_o),
        .tx_phase_o  (tx_phase),
        .done_o      (done_o),
        .ctrl_o      (ctrl)
    );

    assign tx_lanes_o = tx_valid_o ? {LANES{expected_bit(tx_phase)}} : '0;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lst_lane_counter #(.REPS(REPS)) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .ctrl_i    (ctrl),
            .rx_bit_i  (rx_lanes_i[g]),
            .verdict_o (verdict[g])
        );
    end

    lst_map_reg #(.LANES(LANES)) u_map (
        .clk       (clk),
        .rst       (rst),
        .capture_i (ctrl.finish),
        .verdict_i (verdict),
        .map_o     (defect_map_o),
        .multi_o   (multi_defect_o)
    );

endmodule

// File: rtl/lst_checker.sv
module lst_checker #(
    parameter int LANES = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             rx_strobe_i,
    input logic             tx_valid_o,
    input logic [LANES-1:0] tx_lanes_o,
    input logic             done_o,
    input logic [LANES-1:0] defect_map_o,
    input logic             multi_defect_o
);

    // R2: idle lanes are driven low
    a_r2_idle_low: assert property (@(posedge clk) disable iff (rst)
        !tx_valid_o |-> (tx_lanes_o == '0));

    // R2: once the zeros pass begins, no ones word follows it
    a_r2_zeros_after_ones: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && tx_lanes_o == '0) |=> (!tx_valid_o || tx_lanes_o == '0));

    // R2: a valid word is uniform across all lanes
    a_r2_uniform_word: assert property (@(posedge clk) disable iff (rst)
        tx_valid_o |-> (tx_lanes_o == '0 || tx_lanes_o == '1));

    // R5: completion follows an accepted strobe
    a_r5_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(rx_strobe_i));

    // R6: the map changes only on the edge where done rises
    a_r6_map_hold: assert property (@(posedge clk) disable iff (rst)
        !$rose(done_o) |-> ($stable(defect_map_o) && $stable(multi_defect_o)));

    // R7: multi flag agrees with the number of flagged lanes
    a_r7_multi_set: assert property (@(posedge clk) disable iff (rst)
        multi_defect_o |-> ($countones(defect_map_o) > 1));
    a_r7_multi_clear: assert property (@(posedge clk) disable iff (rst)
        !multi_defect_o |-> ($countones(defect_map_o) <= 1));

    // R8: a rerun request while done drops done on the next edge
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        (done_o && start_i) |=> !done_o);

    // R9: nothing is transmitted while the result is held
    a_r9_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !tx_valid_o);

endmodule

bind lane_selftest_mapper lst_checker #(.LANES(LANES)) u_lst_chk (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .rx_strobe_i    (rx_strobe_i),
    .tx_valid_o     (tx_valid_o),
    .tx_lanes_o     (tx_lanes_o),
    .done_o         (done_o),
    .defect_map_o   (defect_map_o),
    .multi_defect_o (multi_defect_o)
);

// File: tb/tb_lane_selftest_mapper.sv
module tb_lane_selftest_mapper;

    localparam int LANES = 32;
    localparam int REPS  = 4;
    localparam int NV    = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic             rx_strobe_i = 1'b0;
    logic [LANES-1:0] rx_lanes_i = '0;
    logic             tx_valid_o;
    logic [LANES-1:0] tx_lanes_o;
    logic             done_o;
    logic [LANES-1:0] defect_map_o;
    logic             multi_defect_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lane_selftest_mapper #(.LANES(LANES), .REPS(REPS)) dut (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .tx_valid_o     (tx_valid_o),
        .tx_lanes_o     (tx_lanes_o),
        .rx_strobe_i    (rx_strobe_i),
        .rx_lanes_i     (rx_lanes_i),
        .done_o         (done_o),
        .defect_map_o   (defect_map_o),
        .multi_defect_o (multi_defect_o)
    );

    // Vector table: stuck-low mask, stuck-high mask, near-miss mask,
    // expected map, expected multi flag, 1 = launch by reset.
    localparam logic [31:0] V_SA0  [NV] = '{32'h0, 32'h0000_0008, 32'h0, 32'h0000_0001, 32'h0, 32'h00F0_0000};
    localparam logic [31:0] V_SA1  [NV] = '{32'h0, 32'h0, 32'h8000_0000, 32'h0000_0002, 32'h0, 32'h0000_0F00};
    localparam logic [31:0] V_NEAR [NV] = '{32'h0, 32'h0, 32'h0000_0020, 32'h0, 32'hFFFF_FFFF, 32'h0000_0001};
    localparam logic [31:0] V_MAP  [NV] = '{32'h0, 32'h0000_0008, 32'h8000_0000, 32'h0000_0003, 32'h0, 32'h00F0_0F00};
    localparam logic        V_MULT [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic        V_RST  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(logic s, logic [LANES-1:0] d);
        @(negedge clk);
        rx_strobe_i = s;
        rx_lanes_i  = d;
    endtask

    function automatic logic [LANES-1:0] sample_word(int i, logic [31:0] sa0,
                                                     logic [31:0] sa1, logic [31:0] near);
        logic [LANES-1:0] p;
        logic [LANES-1:0] d;
        p = (i < REPS) ? '1 : '0;
        d = (p & ~sa0) | sa1;
        if ((i % REPS) != REPS - 1) d = d ^ near;
        return d;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rx_strobe_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 done falls after start", 32'(done_o), 32'h0);
        @(negedge clk);
    endtask

    // Feed 2*REPS strobed words with gap cycles of inverted data between them.
    task automatic feed(logic [31:0] sa0, logic [31:0] sa1, logic [31:0] near,
                        int gap, logic [31:0] prev_map, logic prev_multi,
                        logic [31:0] exp_map, logic exp_multi);
        for (int i = 0; i < 2 * REPS; i++) begin
            if (i == 2 * REPS - 1) begin
                chk("R6 map held before completion", defect_map_o, prev_map);
                chk("R6 multi held before completion", 32'(multi_defect_o), 32'(prev_multi));
                chk("R5 done low before last word", 32'(done_o), 32'h0);
            end
            put(1'b1, sample_word(i, sa0, sa1, near));
            for (int g = 0; g < gap; g++) begin
                put(1'b0, ~sample_word(i, 32'h0, 32'h0, 32'h0));
            end
        end
        put(1'b0, '0);
        chk("R5 done after last word", 32'(done_o), 32'h1);
        chk("R4 defect map", defect_map_o, exp_map);
        chk("R7 multi flag", 32'(multi_defect_o), 32'(exp_multi));
    endtask

    initial begin
        logic [31:0] prev_map;
        logic        prev_multi;

        // Reset state
        @(negedge clk);
        @(negedge clk);
        chk("R6 reset map", defect_map_o, 32'h0);
        chk("R6 reset multi", 32'(multi_defect_o), 32'h0);
        chk("R1 done low in reset", 32'(done_o), 32'h0);
        chk("R2 no tx in reset", 32'(tx_valid_o), 32'h0);
        rst = 1'b0;

        // R1 / R2: transmit sequence without any start request
        for (int k = 0; k <= 2 * REPS; k++) begin
            @(negedge clk);
            if (k < 2 * REPS) begin
                chk("R1 R2 tx valid", 32'(tx_valid_o), 32'h1);
                chk("R2 tx word", tx_lanes_o, (k < REPS) ? 32'hFFFF_FFFF : 32'h0);
            end else begin
                chk("R2 tx stops", 32'(tx_valid_o), 32'h0);
                chk("R2 idle lanes low", tx_lanes_o, 32'h0);
            end
        end
        chk("R3 no done without strobes", 32'(done_o), 32'h0);
        feed(32'h0000_0010, 32'h0, 32'h0, 1, 32'h0, 1'b0, 32'h0000_0010, 1'b0);
        prev_map = 32'h0000_0010;
        prev_multi = 1'b0;

        // Vector table
        for (int v = 0; v < NV; v++) begin
            if (V_RST[v]) begin
                do_reset();
                prev_map = 32'h0;
                prev_multi = 1'b0;
            end else begin
                do_start();
            end
            feed(V_SA0[v], V_SA1[v], V_NEAR[v], v % 3, prev_map, prev_multi,
                 V_MAP[v], V_MULT[v]);
            prev_map = V_MAP[v];
            prev_multi = V_MULT[v];
        end

        // R9: strobes while done change nothing
        for (int i = 0; i < 2 * REPS; i++) begin
            put(1'b1, 32'h0F0F_0F0F);
        end
        put(1'b0, '0);
        chk("R9 map unchanged after strobes in done", defect_map_o, prev_map);
        chk("R9 multi unchanged", 32'(multi_defect_o), 32'(prev_multi));
        chk("R9 done stays high", 32'(done_o), 32'h1);

        // R8: start while running is ignored
        do_start();
        for (int i = 0; i < 3; i++) put(1'b1, sample_word(i, 32'h80, 32'h0, 32'h0));
        @(negedge clk);
        start_i = 1'b1;
        rx_strobe_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 busy start ignored", 32'(done_o), 32'h0);
        for (int i = 3; i < 2 * REPS; i++) put(1'b1, sample_word(i, 32'h80, 32'h0, 32'h0));
        put(1'b0, '0);
        chk("R8 run completes after busy start", 32'(done_o), 32'h1);
        chk("R8 map after busy start", defect_map_o, 32'h0000_0080);

        // R4 boundary: all lanes stuck high, one pass fully failed
        do_start();
        feed(32'h0, 32'hFFFF_FFFF, 32'h0, 0, 32'h0000_0080, 1'b0, 32'hFFFF_FFFF, 1'b1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule